// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Timer

This block produces four independent pulse-width-modulated outputs. Software programs it through a small memory-mapped register port. Each channel counts down from a 16-bit period value. Its output is high during the final part of each period, and a 16-bit compare value sets how long that part is. The count clock for a channel comes from the bus clock in two stages. The first stage is an 8-bit prescaler field, which two neighbouring channels share. The second stage is a divider chosen per channel by a 3-bit code.

A channel starts when software sets its enable bit while that bit is clear. It then runs either continuously, reloading at the end of every period, or for one period only. Period and compare values written while a channel runs are held back until the channel's next reload, so no period is ever a mix of old and new settings. Reads return the stored register contents one cycle after the read strobe.

Top module: `quad_pwm_timer`

## Requirements
- R1: Synchronous active-low reset clears every register, the read data and all four outputs to zero.
- R2: Reads return stored values one cycle after `rd_en`, with undefined bits reading as zero. The byte offsets are:
  - 0x00: prescaler fields in [15:0].
  - 0x04: a 3-bit divide code per channel c at [4c+2:4c].
  - 0x08: control bits.
  - 0x0C+12c: period value in [15:0].
  - 0x10+12c: compare value in [15:0].
- R3: A running channel with prescaler field P, divider D, period value N and compare value M repeats every (P+1)·D·(N+1) bus clocks. On the clock edge that starts the channel its count is loaded with N. Each count step lasts (P+1)·D clocks. The output is high while the count is at most M, so it is high for (M+1) steps of every period when M < N.
- R4: Channels 0 and 1 take their prescaler from offset 0x00 bits [7:0]; channels 2 and 3 take theirs from bits [15:8].
- R5: A prescaler field of zero freezes the count of both channels of that pair, so their outputs hold their value.
- R6: Each divide code selects a divider: 4 gives 1, 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 16, and codes 5, 6 and 7 give 1.
- R7: At offset 0x08, channel 0 has its enable bit at bit 0 and its continuous-mode bit at bit 3. Channel n≥1 has its enable bit at bit 4+4n and its continuous-mode bit at bit 7+4n.
- R8: With the continuous-mode bit clear, a channel runs one period, then stops with its output low, and its enable bit stays set.
- R9: Writing a channel's enable bit to 0 drives its output low from the next cycle, and the continuous-mode bit keeps the value written with it.
- R10: Period and compare values written while a channel runs take effect only at that channel's next reload.
- R11: Setting an enable bit that was clear restarts that channel's prescaler and divider counts from zero, so the first step is a full step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data valid the next cycle |
| rdata | output | 32 | Registered read data |
| pwm | output | 4 | Channel outputs, bit c for channel c |

## Verification
Duty measurements are taken over whole periods, starting from the enable edge. They use a short period with a prescaler of 2 across all eight divide codes. A mismatch in the code-to-divider mapping, or a counter that does not restart on enable, therefore shows up as a wrong high-time count. A channel of the upper pair is run with a different prescaler byte, which shows whether the prescaler field is picked by pair. Further runs cover:
- a one-shot run;
- a period and compare update made in the middle of a period, where the expected high time differs depending on whether the update is shadowed or applied at once;
- a zero prescaler;
- a disable made while the channel runs.

A behavioural model checks every output on every cycle during all of these runs.

// File: rtl/quad_pwm_timer.sv
module quad_pwm_timer #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [31:0]   rdata,
  output logic [3:0]    pwm
);
  localparam int NCH = 4;
  localparam logic [AW-1:0] A_PSC  = AW'(0);
  localparam logic [AW-1:0] A_DIV  = AW'(4);
  localparam logic [AW-1:0] A_CTRL = AW'(8);

  function automatic int en_bit(int c);
    return (c == 0) ? 0 : 4 + 4 * c;
  endfunction
  function automatic logic [AW-1:0] per_addr(int c);
    return AW'(12 + 12 * c);
  endfunction
  function automatic logic [AW-1:0] cmp_addr(int c);
    return AW'(16 + 12 * c);
  endfunction

  logic [2*PW-1:0]       psc_q;
  logic [NCH-1:0][2:0]   dsel_q;
  logic [NCH-1:0]        en_q, ar_q, run_q;
  logic [NCH-1:0][CW-1:0] per_q, cmp_q, cnt_q, per_sh_q, cmp_sh_q;
  logic [NCH-1:0][PW-1:0] pc_q, psel;
  logic [NCH-1:0][3:0]   dc_q, dmask;
  logic [NCH-1:0]        ptick, tick, start, stop;
  logic [31:0]           rd_mux;
  logic                  ctrl_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      psel[c] = psc_q[(c/2)*PW +: PW];
      case (dsel_q[c])
        3'd0:    dmask[c] = 4'h1;
        3'd1:    dmask[c] = 4'h3;
        3'd2:    dmask[c] = 4'h7;
        3'd3:    dmask[c] = 4'hF;
        default: dmask[c] = 4'h0;
      endcase
      ptick[c] = (psel[c] != '0) && (pc_q[c] == psel[c]);
      tick[c]  = ptick[c] && ((dc_q[c] & dmask[c]) == dmask[c]);
      start[c] = ctrl_wr && wdata[en_bit(c)] && !en_q[c];
      stop[c]  = ctrl_wr && !wdata[en_bit(c)];
      pwm[c]   = run_q[c] && (cnt_q[c] <= cmp_sh_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q <= '0; dsel_q <= '0; en_q <= '0; ar_q <= '0;
      per_q <= '0; cmp_q <= '0;
    end else if (wr_en) begin
      if (addr == A_PSC) psc_q <= wdata[2*PW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (addr == A_DIV)  dsel_q[c] <= wdata[4*c +: 3];
        if (addr == A_CTRL) begin
          en_q[c] <= wdata[en_bit(c)];
          ar_q[c] <= wdata[en_bit(c) + 3];
        end
        if (addr == per_addr(c)) per_q[c] <= wdata[CW-1:0];
        if (addr == cmp_addr(c)) cmp_q[c] <= wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0; cnt_q <= '0; per_sh_q <= '0; cmp_sh_q <= '0;
      pc_q <= '0; dc_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (start[c]) begin
          run_q[c]    <= 1'b1;
          cnt_q[c]    <= per_q[c];
          per_sh_q[c] <= per_q[c];
          cmp_sh_q[c] <= cmp_q[c];
          pc_q[c]     <= '0;
          dc_q[c]     <= '0;
        end else if (stop[c]) begin
          run_q[c] <= 1'b0;
        end else if (run_q[c] && psel[c] != '0) begin
          pc_q[c] <= ptick[c] ? '0 : pc_q[c] + 1'b1;
          if (ptick[c]) dc_q[c] <= dc_q[c] + 1'b1;
          if (tick[c]) begin
            if (cnt_q[c] != '0) begin
              cnt_q[c] <= cnt_q[c] - 1'b1;
            end else if (ar_q[c]) begin
              cnt_q[c]    <= per_q[c];
              per_sh_q[c] <= per_q[c];
              cmp_sh_q[c] <= cmp_q[c];
            end else begin
              run_q[c] <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PSC:  rd_mux[2*PW-1:0] = psc_q;
      A_DIV:  for (int c = 0; c < NCH; c++) rd_mux[4*c +: 3] = dsel_q[c];
      A_CTRL: for (int c = 0; c < NCH; c++) begin
                rd_mux[en_bit(c)]     = en_q[c];
                rd_mux[en_bit(c) + 3] = ar_q[c];
              end
      default: for (int c = 0; c < NCH; c++) begin
                 if (addr == per_addr(c)) rd_mux[CW-1:0] = per_q[c];
                 if (addr == cmp_addr(c)) rd_mux[CW-1:0] = cmp_q[c];
               end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/quad_pwm_timer_chk.sv
module quad_pwm_timer_chk #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_wr,
  input logic [2*PW-1:0]     psc_q,
  input logic [3:0]          en_q,
  input logic [3:0]          ar_q,
  input logic [3:0]          run_q,
  input logic [3:0][CW-1:0]  cnt_q,
  input logic [3:0][CW-1:0]  per_sh_q,
  input logic [3:0]          pwm
);
  for (genvar c = 0; c < 4; c++) begin : g_ch
    p_dis_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[c] |-> !pwm[c]);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q[c] |-> (cnt_q[c] <= per_sh_q[c]));
    p_psc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (psc_q[(c/2)*PW +: PW] == '0 && !ctrl_wr) |=> $stable(pwm[c]));
    p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q[c]) && !$past(ctrl_wr)) |-> (!$past(ar_q[c]) && en_q[c]));
    p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ctrl_wr) && $rose(en_q[c])) |-> (run_q[c] && cnt_q[c] == per_sh_q[c]));
  end
endmodule

bind quad_pwm_timer quad_pwm_timer_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .psc_q(psc_q), .en_q(en_q),
  .ar_q(ar_q), .run_q(run_q), .cnt_q(cnt_q), .per_sh_q(per_sh_q), .pwm(pwm)
);

// File: tb/quad_pwm_timer_tb.sv
`timescale 1ns/1ps
module quad_pwm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  quad_pwm_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pwm(pwm));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string tag = "R1";
  int hc [4];

  // behavioural model
  int m_psc, m_dsel [4], m_per [4], m_cmp [4];
  bit m_en [4], m_ar [4], m_run [4];
  int m_cnt [4], m_pers [4], m_cmps [4], m_acc [4];

  function automatic int divv(int code);
    case (code)
      0: return 2; 1: return 4; 2: return 8; 3: return 16;
      default: return 1;
    endcase
  endfunction
  function automatic int ebit(int c);
    return (c == 0) ? 0 : 4 + 4 * c;
  endfunction
  function automatic int m_read(int a);
    int v = 0;
    if (a == 0) v = m_psc;
    if (a == 4) for (int c = 0; c < 4; c++) v |= m_dsel[c] << (4 * c);
    if (a == 8) for (int c = 0; c < 4; c++)
      v |= (int'(m_en[c]) << ebit(c)) | (int'(m_ar[c]) << (ebit(c) + 3));
    for (int c = 0; c < 4; c++) begin
      if (a == 12 + 12 * c) v = m_per[c];
      if (a == 16 + 12 * c) v = m_cmp[c];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 0;
      for (int c = 0; c < 4; c++) begin
        m_dsel[c] = 0; m_per[c] = 0; m_cmp[c] = 0; m_en[c] = 0; m_ar[c] = 0;
        m_run[c] = 0; m_cnt[c] = 0; m_pers[c] = 0; m_cmps[c] = 0; m_acc[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        int p;
        p = (m_psc >> (8 * (c / 2))) & 8'hFF;
        if (wr_en && addr == 8 && wdata[ebit(c)] && !m_en[c]) begin
          m_run[c] = 1; m_cnt[c] = m_per[c]; m_pers[c] = m_per[c];
          m_cmps[c] = m_cmp[c]; m_acc[c] = 0;
        end else if (wr_en && addr == 8 && !wdata[ebit(c)]) begin
          m_run[c] = 0;
        end else if (m_run[c] && p != 0) begin
          m_acc[c]++;
          if (m_acc[c] == (p + 1) * divv(m_dsel[c])) begin
            m_acc[c] = 0;
            if (m_cnt[c] != 0) m_cnt[c]--;
            else if (m_ar[c]) begin
              m_cnt[c] = m_per[c]; m_pers[c] = m_per[c]; m_cmps[c] = m_cmp[c];
            end else m_run[c] = 0;
          end
        end
      end
      if (wr_en) begin
        if (addr == 0) m_psc = wdata[15:0];
        for (int c = 0; c < 4; c++) begin
          if (addr == 4) m_dsel[c] = int'(wdata[4*c +: 3]);
          if (addr == 8) begin m_en[c] = wdata[ebit(c)]; m_ar[c] = wdata[ebit(c)+3]; end
          if (addr == 12 + 12 * c) m_per[c] = wdata[15:0];
          if (addr == 16 + 12 * c) m_cmp[c] = wdata[15:0];
        end
      end
    end
  end

  task automatic chk(bit ok, string t, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < 4; c++) if (pwm[c]) hc[c]++;
    if (rst_n) begin
      logic [3:0] e;
      for (int c = 0; c < 4; c++) e[c] = m_run[c] && (m_cnt[c] <= m_cmps[c]);
      chk(pwm == e, tag, int'(pwm), int'(e));
    end
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; addr = 8'(a); wdata = d; wr_en = 1;
    @(negedge clk); #1; wr_en = 0;
  endtask
  task automatic start(int d);
    @(negedge clk); #1; addr = 8; wdata = d; wr_en = 1;
    for (int c = 0; c < 4; c++) hc[c] = 0;
    @(negedge clk); #1; wr_en = 0;
  endtask
  task automatic rd(int a, int exp, string t);
    @(negedge clk); #1; addr = 8'(a); rd_en = 1;
    @(negedge clk); #1; rd_en = 0;
    chk(rdata == exp, t, int'(rdata), exp);
  endtask
  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0;
    repeat (2) @(negedge clk); #1; rst_n = 1;
  endtask
  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    do_reset();
    tag = "R1";
    chk(pwm == 0, "R1 outputs", int'(pwm), 0);
    rd(0, 0, "R1 psc"); rd(8, 0, "R1 ctrl"); rd(12, 0, "R1 per0"); rd(52, 0, "R1 cmp3");

    tag = "R2";
    for (int a = 0; a <= 52; a += 4) wr(a, 32'hFFFF_FFFF);
    rd(0, 32'h0000_FFFF, "R2 psc"); rd(4, 32'h0000_7777, "R2 dsel");
    rd(8, 32'h0009_9909, "R7 ctrl bits"); rd(24, 32'h0000_FFFF, "R2 per1");
    rd(52, 32'h0000_FFFF, "R2 cmp3"); rd(56, 0, "R2 unmapped");
    do_reset();

    tag = "R3";
    wr(0, 32'h0301); wr(4, 32'h4444); wr(12, 3); wr(16, 1);
    start(32'h9);
    wait_n(79);
    chk(hc[0] == 40, "R3 high time", hc[0], 40);

    tag = "R6";
    for (int code = 0; code < 8; code++) begin
      int exp;
      wr(8, 0); wr(4, code);
      start(32'h9);
      wait_n(16 * divv(code) - 1);
      exp = 8 * divv(code);
      chk(hc[0] == exp, $sformatf("R6 R11 code %0d", code), hc[0], exp);
    end

    tag = "R4";
    wr(8, 0); wr(4, 32'h4444); wr(36, 1); wr(40, 0);
    start(32'h9000);
    wait_n(31);
    chk(hc[2] == 16, "R4 upper pair prescaler", hc[2], 16);

    tag = "R7";
    wr(8, 0); wr(24, 0); wr(28, 0);
    start(32'h100);
    chk(pwm[1] == 1'b1, "R7 ch1 enable bit", int'(pwm[1]), 1);
    wait_n(8);
    chk(pwm[1] == 1'b0, "R7 ch1 one-shot end", int'(pwm[1]), 0);

    tag = "R8";
    wr(8, 0); wr(12, 2); wr(16, 0);
    start(32'h1);
    wait_n(19);
    chk(hc[0] == 2, "R8 one-shot high time", hc[0], 2);
    chk(pwm[0] == 1'b0, "R8 stopped low", int'(pwm[0]), 0);
    rd(8, 32'h1, "R8 enable kept");

    tag = "R9";
    wr(8, 0); wr(16, 2);
    start(32'h9);
    wait_n(3);
    wr(8, 32'h8);
    chk(pwm[0] == 1'b0, "R9 disabled low", int'(pwm[0]), 0);
    rd(8, 32'h8, "R9 mode bit kept");

    tag = "R10";
    wr(12, 3); wr(16, 1);
    start(32'h9);
    wr(12, 7); wr(16, 3);
    wait_n(21);
    chk(hc[0] == 12, "R10 shadowed update", hc[0], 12);

    tag = "R5";
    wr(8, 0); wr(0, 32'h0300); wr(12, 3); wr(16, 1);
    start(32'h9);
    wait_n(39);
    chk(hc[0] == 0, "R5 frozen count", hc[0], 0);
    wr(12, 0); wr(16, 5); wr(8, 0);
    start(32'h9);
    wait_n(19);
    chk(hc[0] == 20, "R5 frozen high", hc[0], 20);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule